// File: doc/BRIEF.md
# Memory Operand Address Generator

This block turns one memory operand description into an address. The description names an addressing form and gives the candidate pointer registers, a displacement and the four segment bases. The block adds the selected base register, index register and displacement to form a 16-bit effective offset. It then picks a segment, either the default that the addressing form implies or an explicit override. The physical address is the segment base shifted left by the segment shift plus the offset.

Results are registered. They appear one clock after a request whose valid bit is set, together with an output valid flag. The block sits between an instruction decoder, which supplies the mode and register choices, and the bus unit, which uses the address. It does no decoding and no memory access of its own.

Top module: `eag_unit`

## Requirements
- R1: Mode code 0 (direct) yields the extended displacement as the offset. Codes 6 and 7 are reserved and behave as code 0.
- R2: Mode code 1 (register indirect) yields one register as the offset, chosen by `i_rsel`: 0 picks SI, 1 picks DI, 2 picks BX and 3 picks BP.
- R3: Mode code 2 (based) adds the extended displacement to BX (`i_bsel`=0) or BP (`i_bsel`=1). Mode code 3 (indexed) adds it to SI (`i_xsel`=0) or DI (`i_xsel`=1).
- R4: Mode code 4 adds the chosen base register to the chosen index register. Mode code 5 also adds the extended displacement to that sum.
- R5: When `i_dwide`=0, only the low 8 bits of `i_disp` are used, sign-extended to 16 bits, and the upper byte has no effect. When `i_dwide`=1, all 16 bits are used.
- R6: Every offset sum wraps modulo 2^16.
- R7: With no override, the segment is SS (id 2) for any form that uses BP as its base (modes 2, 4 and 5 with `i_bsel`=1, or mode 1 with `i_rsel`=3). Every other form uses DS (id 3).
- R8: With `i_ovr_en`=1, the segment is `i_ovr_sel`, using the ids 0=ES, 1=CS, 2=SS and 3=DS.
- R9: `o_phys` equals the selected segment value times 16 plus the offset, taken modulo 2^20.
- R10: `o_valid` equals `i_valid` from the previous clock, and the data outputs appear one clock after a valid request. While `i_valid` is 0, the data outputs hold their last values.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_valid | input | 1 | Request valid |
| i_mode | input | 3 | Addressing mode code |
| i_bsel | input | 1 | Base choice: 0 BX, 1 BP |
| i_xsel | input | 1 | Index choice: 0 SI, 1 DI |
| i_rsel | input | 2 | Register-indirect choice: 0 SI, 1 DI, 2 BX, 3 BP |
| i_disp | input | 16 | Displacement |
| i_dwide | input | 1 | 1: 16-bit displacement, 0: sign-extended low byte |
| i_bx | input | 16 | BX value |
| i_bp | input | 16 | BP value |
| i_si | input | 16 | SI value |
| i_di | input | 16 | DI value |
| i_seg_es | input | 16 | ES value |
| i_seg_cs | input | 16 | CS value |
| i_seg_ss | input | 16 | SS value |
| i_seg_ds | input | 16 | DS value |
| i_ovr_en | input | 1 | Segment override enable |
| i_ovr_sel | input | 2 | Override segment id |
| o_valid | output | 1 | Result valid |
| o_offset | output | 16 | Effective offset |
| o_seg | output | 2 | Selected segment id |
| o_phys | output | 20 | Physical address |

## Verification
The bench builds the block with its default parameters: a 16-bit offset, a segment shift of 4 and an 8-bit short displacement, which gives a 20-bit physical address. These values make both wrap points reachable with small directed operands. One is the 16-bit offset wrap, when DI plus a displacement crosses 0xFFFF. The other is the 20-bit address wrap, when the segment is 0xFFFF and the offset is 0xFFFF. The short width also leaves a spare upper displacement byte that the bench fills with noise, to show that it is ignored.

// File: rtl/eag_pkg.sv
package eag_pkg;
   typedef enum logic [2:0] {
      AM_DIRECT    = 3'd0,
      AM_REGIND    = 3'd1,
      AM_BASED     = 3'd2,
      AM_INDEXED   = 3'd3,
      AM_BIDX      = 3'd4,
      AM_BIDX_DISP = 3'd5
   } am_e;

   localparam logic [1:0] SEG_ES = 2'd0;
   localparam logic [1:0] SEG_CS = 2'd1;
   localparam logic [1:0] SEG_SS = 2'd2;
   localparam logic [1:0] SEG_DS = 2'd3;

   localparam logic [1:0] RSEL_SI = 2'd0;
   localparam logic [1:0] RSEL_DI = 2'd1;
   localparam logic [1:0] RSEL_BX = 2'd2;
   localparam logic [1:0] RSEL_BP = 2'd3;
endpackage

// File: rtl/eag_disp_ext.sv
module eag_disp_ext #(
   parameter int OFS_W   = 16,
   parameter int SHORT_W = 8
) (
   input  logic [OFS_W-1:0] disp,
   input  logic             wide,
   output logic [OFS_W-1:0] ext
);
   localparam int PAD_W = OFS_W - SHORT_W;

   generate
      if (PAD_W == 0) begin : g_same
         assign ext = disp;
      end else begin : g_sext
         logic [SHORT_W-1:0] short_part;
         assign short_part = disp[SHORT_W-1:0];
         assign ext = wide ? disp : {{PAD_W{short_part[SHORT_W-1]}}, short_part};
      end
   endgenerate
endmodule

// File: rtl/eag_offset.sv
module eag_offset
   import eag_pkg::*;
#(
   parameter int OFS_W = 16
) (
   input  logic [2:0]       mode,
   input  logic             bsel,
   input  logic             xsel,
   input  logic [1:0]       rsel,
   input  logic [OFS_W-1:0] disp_x,
   input  logic [OFS_W-1:0] bx,
   input  logic [OFS_W-1:0] bp,
   input  logic [OFS_W-1:0] si,
   input  logic [OFS_W-1:0] di,
   output logic [OFS_W-1:0] offset
);
   logic [OFS_W-1:0] base_v, idx_v, ind_v;

   assign base_v = bsel ? bp : bx;
   assign idx_v  = xsel ? di : si;

   always_comb begin
      case (rsel)
         RSEL_SI: ind_v = si;
         RSEL_DI: ind_v = di;
         RSEL_BX: ind_v = bx;
         default: ind_v = bp;
      endcase
   end

   always_comb begin
      case (mode)
         AM_REGIND:    offset = ind_v;
         AM_BASED:     offset = base_v + disp_x;
         AM_INDEXED:   offset = idx_v + disp_x;
         AM_BIDX:      offset = base_v + idx_v;
         AM_BIDX_DISP: offset = base_v + idx_v + disp_x;
         default:      offset = disp_x;
      endcase
   end
endmodule

// File: rtl/eag_seg_sel.sv
module eag_seg_sel
   import eag_pkg::*;
(
   input  logic [2:0] mode,
   input  logic       bsel,
   input  logic [1:0] rsel,
   input  logic       ovr_en,
   input  logic [1:0] ovr_sel,
   output logic [1:0] seg_id
);
   logic bp_form;

   always_comb begin
      case (mode)
         AM_BASED, AM_BIDX, AM_BIDX_DISP: bp_form = bsel;
         AM_REGIND:                       bp_form = (rsel == RSEL_BP);
         default:                         bp_form = 1'b0;
      endcase
   end

   assign seg_id = ovr_en ? ovr_sel : (bp_form ? SEG_SS : SEG_DS);
endmodule

// File: rtl/eag_unit.sv
module eag_unit
   import eag_pkg::*;
#(
   parameter int OFS_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int SHORT_W   = 8,
   localparam int ADDR_W   = OFS_W + SEG_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_valid,
   input  logic [2:0]        i_mode,
   input  logic              i_bsel,
   input  logic              i_xsel,
   input  logic [1:0]        i_rsel,
   input  logic [OFS_W-1:0]  i_disp,
   input  logic              i_dwide,
   input  logic [OFS_W-1:0]  i_bx,
   input  logic [OFS_W-1:0]  i_bp,
   input  logic [OFS_W-1:0]  i_si,
   input  logic [OFS_W-1:0]  i_di,
   input  logic [OFS_W-1:0]  i_seg_es,
   input  logic [OFS_W-1:0]  i_seg_cs,
   input  logic [OFS_W-1:0]  i_seg_ss,
   input  logic [OFS_W-1:0]  i_seg_ds,
   input  logic              i_ovr_en,
   input  logic [1:0]        i_ovr_sel,
   output logic              o_valid,
   output logic [OFS_W-1:0]  o_offset,
   output logic [1:0]        o_seg,
   output logic [ADDR_W-1:0] o_phys
);
   generate
      if (SHORT_W < 1 || SHORT_W > OFS_W) begin : g_bad_short
         $error("eag_unit: SHORT_W must lie in 1..OFS_W");
      end
      if (SEG_SHIFT < 1 || SEG_SHIFT > 16) begin : g_bad_shift
         $error("eag_unit: SEG_SHIFT must lie in 1..16");
      end
      if (OFS_W < 2) begin : g_bad_ofs
         $error("eag_unit: OFS_W too small");
      end
   endgenerate

   logic [OFS_W-1:0]  disp_x, ofs_d, seg_val;
   logic [1:0]        seg_d;
   logic [ADDR_W-1:0] phys_d;

   eag_disp_ext #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_dext (
      .disp (i_disp),
      .wide (i_dwide),
      .ext  (disp_x)
   );

   eag_offset #(.OFS_W(OFS_W)) u_ofs (
      .mode   (i_mode),
      .bsel   (i_bsel),
      .xsel   (i_xsel),
      .rsel   (i_rsel),
      .disp_x (disp_x),
      .bx     (i_bx),
      .bp     (i_bp),
      .si     (i_si),
      .di     (i_di),
      .offset (ofs_d)
   );

   eag_seg_sel u_seg (
      .mode    (i_mode),
      .bsel    (i_bsel),
      .rsel    (i_rsel),
      .ovr_en  (i_ovr_en),
      .ovr_sel (i_ovr_sel),
      .seg_id  (seg_d)
   );

   always_comb begin
      case (seg_d)
         SEG_ES:  seg_val = i_seg_es;
         SEG_CS:  seg_val = i_seg_cs;
         SEG_SS:  seg_val = i_seg_ss;
         default: seg_val = i_seg_ds;
      endcase
   end

   assign phys_d = {seg_val, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ofs_d};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid  <= 1'b0;
         o_offset <= '0;
         o_seg    <= '0;
         o_phys   <= '0;
      end else begin
         o_valid <= i_valid;
         if (i_valid) begin
            o_offset <= ofs_d;
            o_seg    <= seg_d;
            o_phys   <= phys_d;
         end
      end
   end

   function automatic logic [OFS_W-1:0] pick_seg(input logic [1:0] id,
      input logic [OFS_W-1:0] es, input logic [OFS_W-1:0] cs,
      input logic [OFS_W-1:0] ss, input logic [OFS_W-1:0] ds);
      case (id)
         2'd0:    return es;
         2'd1:    return cs;
         2'd2:    return ss;
         default: return ds;
      endcase
   endfunction

   // R10
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid == $past(i_valid));

   // R10
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(i_valid) |-> ($stable(o_offset) && $stable(o_seg) && $stable(o_phys)));

   // R8
   override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(i_valid && i_ovr_en) |-> o_seg == $past(i_ovr_sel));

   // R1
   direct_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(i_valid && i_mode == 3'd0 && i_dwide) |-> o_offset == $past(i_disp));

   // R9
   phys_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(i_valid) |-> o_phys == ADDR_W'({pick_seg(o_seg, $past(i_seg_es), $past(i_seg_cs),
         $past(i_seg_ss), $past(i_seg_ds)), {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, o_offset}));
endmodule

// File: tb/sim_eag_unit.sv
module sim_eag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_valid = 1'b0;
   logic [2:0]  i_mode = '0;
   logic        i_bsel = 1'b0, i_xsel = 1'b0;
   logic [1:0]  i_rsel = '0;
   logic [15:0] i_disp = '0;
   logic        i_dwide = 1'b1;
   logic [15:0] i_bx = 16'h1234, i_bp = 16'h2000, i_si = 16'h0010, i_di = 16'hFFF0;
   logic [15:0] i_seg_es = 16'h4000, i_seg_cs = 16'h1000, i_seg_ss = 16'h3000, i_seg_ds = 16'h2000;
   logic        i_ovr_en = 1'b0;
   logic [1:0]  i_ovr_sel = '0;
   logic        o_valid;
   logic [15:0] o_offset;
   logic [1:0]  o_seg;
   logic [19:0] o_phys;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   eag_unit u0 (.*);

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic issue(input logic [2:0] m, input logic bs, input logic xs, input logic [1:0] rs,
                        input logic [15:0] d, input logic w, input logic oe, input logic [1:0] os);
      @(negedge clk);
      i_mode = m; i_bsel = bs; i_xsel = xs; i_rsel = rs; i_disp = d; i_dwide = w;
      i_ovr_en = oe; i_ovr_sel = os; i_valid = 1'b1;
      @(negedge clk);
      i_valid = 1'b0;
   endtask

   task automatic expect3(input string req, input logic [15:0] ofs, input logic [1:0] sg,
                          input logic [19:0] ph);
      chk(req, {31'd0, o_valid}, 32'd1);
      chk(req, {16'd0, o_offset}, {16'd0, ofs});
      chk(req, {30'd0, o_seg}, {30'd0, sg});
      chk(req, {12'd0, o_phys}, {12'd0, ph});
   endtask

   task automatic t_reset;
      chk("R11 valid", {31'd0, o_valid}, 32'd0);
      chk("R11 phys", {12'd0, o_phys}, 32'd0);
      chk("R11 offset", {16'd0, o_offset}, 32'd0);
   endtask

   task automatic t_direct;
      issue(3'd0, 0, 0, 0, 16'h5678, 1, 0, 0);
      expect3("R1 direct", 16'h5678, 2'd3, 20'h25678);
      issue(3'd7, 0, 0, 0, 16'h0042, 1, 0, 0);
      expect3("R1 reserved", 16'h0042, 2'd3, 20'h20042);
   endtask

   task automatic t_regind;
      issue(3'd1, 0, 0, 2'd3, 16'h9999, 1, 0, 0);
      expect3("R2 R7 ind BP", 16'h2000, 2'd2, 20'h32000);
      issue(3'd1, 0, 0, 2'd1, 16'h9999, 1, 0, 0);
      expect3("R2 ind DI", 16'hFFF0, 2'd3, 20'h2FFF0);
      issue(3'd1, 0, 0, 2'd2, 16'h0, 1, 0, 0);
      expect3("R2 ind BX", 16'h1234, 2'd3, 20'h21234);
   endtask

   task automatic t_based_indexed;
      issue(3'd2, 0, 0, 0, 16'h0080, 0, 0, 0);
      expect3("R3 R5 based BX short neg", 16'h11B4, 2'd3, 20'h211B4);
      issue(3'd3, 0, 1, 0, 16'h0020, 1, 0, 0);
      expect3("R3 R6 indexed DI wrap", 16'h0010, 2'd3, 20'h20010);
      issue(3'd2, 0, 0, 0, 16'hAB7F, 0, 0, 0);
      expect3("R5 upper byte ignored", 16'h12B3, 2'd3, 20'h212B3);
   endtask

   task automatic t_bidx;
      issue(3'd4, 1, 0, 0, 16'h7777, 1, 0, 0);
      expect3("R4 R7 BP+SI", 16'h2010, 2'd2, 20'h32010);
      issue(3'd5, 0, 1, 0, 16'h0005, 0, 0, 0);
      expect3("R4 BX+DI+disp", 16'h1229, 2'd3, 20'h21229);
   endtask

   task automatic t_override;
      issue(3'd2, 1, 0, 0, 16'h0000, 1, 1, 2'd0);
      expect3("R8 BP to ES", 16'h2000, 2'd0, 20'h42000);
      issue(3'd0, 0, 0, 0, 16'h0100, 1, 1, 2'd1);
      expect3("R8 direct to CS", 16'h0100, 2'd1, 20'h10100);
   endtask

   task automatic t_phys_wrap;
      i_seg_ds = 16'hFFFF;
      issue(3'd0, 0, 0, 0, 16'hFFFF, 1, 0, 0);
      expect3("R9 20-bit wrap", 16'hFFFF, 2'd3, 20'h0FFEF);
      i_seg_ds = 16'h2000;
   endtask

   task automatic t_hold;
      @(negedge clk);
      i_mode = 3'd0; i_disp = 16'hBEEF; i_ovr_en = 1'b1; i_ovr_sel = 2'd1;
      @(negedge clk);
      chk("R10 idle valid", {31'd0, o_valid}, 32'd0);
      chk("R10 hold offset", {16'd0, o_offset}, 32'h0000FFFF);
      chk("R10 hold seg", {30'd0, o_seg}, 32'd3);
      chk("R10 hold phys", {12'd0, o_phys}, 32'h0000FFEF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_direct();
      t_regind();
      t_based_indexed();
      t_bidx();
      t_override();
      t_phys_wrap();
      t_hold();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule